// File: doc/BRIEF.md
# Oscillator Stabilization Status Counter

This block measures how long the main crystal oscillator has been running since it last started. It runs on the oscillator's own clock and counts cycles while the oscillator is enabled in crystal mode. Software sees the progress as an 8-bit status byte that fills with ones from the most significant bit downward as the count passes successive powers of two. Any single bit of that byte can also be read through a bit-select port.

The count goes back to zero in four cases: a system reset, a stop-mode entry pulse, a stop-mode release pulse, and an accepted write of 1 to the oscillator stop bit. After a stop release, counting starts again from zero.

The block also holds the oscillator stop bit. A write of 1 to that bit is allowed only while the CPU clock selection does not use the high-speed system clock. A disallowed write leaves the bit unchanged and raises a one-cycle error pulse.

Top module: `oscSettleStatus`

## Requirements
- R1: After reset, `statusByte` reads 8'h00, `mainStop` reads 1 and `wrReject` reads 0.
- R2: The count advances by one on each clock edge only while `extClkSel` is 0, `oscModeSel` is 1 and the registered `mainStop` is 0. Otherwise `statusByte` holds its value.
- R3: Bit 7-i of `statusByte` (i = 0..7) is 1 exactly when the count is at least 2^(8+i). Bit 7 therefore sets after 256 counting edges and the byte reads 8'hFF after 32768. The count then saturates and the byte stays 8'hFF.
- R4: A `stopEnter` pulse makes `statusByte` read 8'h00 after that clock edge.
- R5: A `stopRelease` pulse resets the count to zero after that clock edge. If the run condition of R2 holds, counting then resumes.
- R6: A write with `wrData` = 1 that is permitted sets `mainStop` to 1 and clears the count at the same edge. A write with `wrData` = 0 sets `mainStop` to 0.
- R7: A write of 1 is permitted when `clkSelLow` = 1, or when `clkSelLow` = 0 and `mainClkSel` = 0. A write of 1 with `clkSelLow` = 0 and `mainClkSel` = 1 leaves `mainStop` and the count untouched.
- R8: `wrReject` is 1 for exactly the one cycle after a rejected write of 1, and is 0 otherwise.
- R9: When a clear and the run condition occur in the same cycle, the clear wins. The first increment happens on the following edge, so bit 7 sets exactly 256 edges after the clearing edge.
- R10: `statusBit` always equals `statusByte[bitSel]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rstN | input | 1 | Active-low synchronous system reset |
| stopEnter | input | 1 | One-cycle pulse on stop-mode entry |
| stopRelease | input | 1 | One-cycle pulse on stop-mode release |
| extClkSel | input | 1 | 1 = external clock input, 0 = crystal |
| oscModeSel | input | 1 | 1 = oscillator operation enabled |
| clkSelLow | input | 1 | CPU clock taken from the low-speed domain |
| mainClkSel | input | 1 | Main clock picks the high-speed system clock |
| wrEn | input | 1 | Write strobe for the stop bit |
| wrData | input | 1 | Value written to the stop bit |
| bitSel | input | 3 | Index of the status bit presented on statusBit |
| statusByte | output | 8 | Thermometer status byte |
| statusBit | output | 1 | Selected bit of the status byte |
| mainStop | output | 1 | Current oscillator stop bit |
| wrReject | output | 1 | One-cycle pulse after a rejected stop write |

## Verification
The bench watches each threshold at the exact edge where it is crossed. A design that is off by one in the counter or the compare would set bit 7 at 255 or 257 edges. It also checks that the count sticks at 8'hFF instead of wrapping to zero. A stop release applied while the oscillator is running checks that the clear takes priority: a design that incremented in the clearing cycle would cross the first threshold one edge early. Writes of 1 are tried under every clock-select combination. A design with the permission rule inverted would stop the oscillator while the CPU still depends on it, and would then miss the reject pulse as well.

// File: rtl/oscSettlePkg.sv
package oscSettlePkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic clear;    // zero the count this edge
    logic advance;  // add one this edge (never together with clear)
  } stepCmd_t;

endpackage

// File: rtl/oscSettleCtrl.sv
module oscSettleCtrl
  import oscSettlePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stopEnter,
  input  logic     stopRelease,
  input  logic     extClkSel,
  input  logic     oscModeSel,
  input  logic     clkSelLow,
  input  logic     mainClkSel,
  input  logic     wrEn,
  input  logic     wrData,
  output logic     mainStop,
  output logic     wrReject,
  output stepCmd_t cmd
);

  logic permitStop;
  logic stopSet;
  logic stopBad;
  logic stopClr;
  logic oscRun;
  logic mainStopQ;
  logic wrRejectQ;

  // Stopping is legal unless the CPU runs from the high-speed system clock
  always_comb begin
    permitStop = clkSelLow || !mainClkSel;
    stopSet    = wrEn && wrData && permitStop;
    stopBad    = wrEn && wrData && !permitStop;
    stopClr    = wrEn && !wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainStopQ <= 1'b1;
      wrRejectQ <= 1'b0;
    end else begin
      if (stopSet)      mainStopQ <= 1'b1;
      else if (stopClr) mainStopQ <= 1'b0;
      wrRejectQ <= stopBad;
    end
  end

  // Clear has priority over counting in the same cycle
  always_comb begin
    oscRun      = !extClkSel && oscModeSel && !mainStopQ;
    cmd.clear   = stopEnter || stopRelease || stopSet;
    cmd.advance = oscRun && !cmd.clear;
  end

  assign mainStop = mainStopQ;
  assign wrReject = wrRejectQ;

endmodule

// File: rtl/oscSettleData.sv
module oscSettleData
  import oscSettlePkg::*;
#(
  parameter int FIRST_EXP = 8,
  parameter int NUM_BITS  = 8,
  parameter int SEL_W     = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  stepCmd_t            cmd,
  input  logic [SEL_W-1:0]    bitSel,
  output logic [NUM_BITS-1:0] statusByte,
  output logic                statusBit
);

  localparam int CNT_W = FIRST_EXP + NUM_BITS;
  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(1) << (FIRST_EXP + NUM_BITS - 1);

  logic [CNT_W-1:0] cycleCnt;
  logic             atSat;

  assign atSat = (cycleCnt == SAT_VAL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (cmd.clear) begin
      cycleCnt <= '0;
    end else if (cmd.advance && !atSat) begin
      cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  // Thermometer from the MSB downward: lowest threshold on the top bit
  for (genvar i = 0; i < NUM_BITS; i++) begin : gThermo
    localparam logic [CNT_W-1:0] THRESH = CNT_W'(1) << (FIRST_EXP + i);
    assign statusByte[NUM_BITS-1-i] = (cycleCnt >= THRESH);
  end

  assign statusBit = statusByte[bitSel];

endmodule

// File: rtl/oscSettleStatus.sv
module oscSettleStatus
  import oscSettlePkg::*;
#(
  parameter int FIRST_EXP = 8,
  parameter int NUM_BITS  = 8,
  parameter int SEL_W     = (NUM_BITS > 1) ? $clog2(NUM_BITS) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                stopEnter,
  input  logic                stopRelease,
  input  logic                extClkSel,
  input  logic                oscModeSel,
  input  logic                clkSelLow,
  input  logic                mainClkSel,
  input  logic                wrEn,
  input  logic                wrData,
  input  logic [SEL_W-1:0]    bitSel,
  output logic [NUM_BITS-1:0] statusByte,
  output logic                statusBit,
  output logic                mainStop,
  output logic                wrReject
);

  stepCmd_t stepCmd;

  oscSettleCtrl uCtrl (
    .clk(clk), .rstN(rstN), .stopEnter(stopEnter), .stopRelease(stopRelease),
    .extClkSel(extClkSel), .oscModeSel(oscModeSel), .clkSelLow(clkSelLow),
    .mainClkSel(mainClkSel), .wrEn(wrEn), .wrData(wrData),
    .mainStop(mainStop), .wrReject(wrReject), .cmd(stepCmd)
  );

  oscSettleData #(.FIRST_EXP(FIRST_EXP), .NUM_BITS(NUM_BITS), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(stepCmd), .bitSel(bitSel),
    .statusByte(statusByte), .statusBit(statusBit)
  );

endmodule

// File: rtl/oscSettleChk.sv
module oscSettleChk #(
  parameter int NUM_BITS = 8,
  parameter int SEL_W    = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                stopEnter,
  input logic                stopRelease,
  input logic                extClkSel,
  input logic                oscModeSel,
  input logic                clkSelLow,
  input logic                mainClkSel,
  input logic                wrEn,
  input logic                wrData,
  input logic [SEL_W-1:0]    bitSel,
  input logic [NUM_BITS-1:0] statusByte,
  input logic                statusBit,
  input logic                mainStop,
  input logic                wrReject
);

  logic badWrite;
  logic [NUM_BITS-1:0] invByte;
  assign badWrite = wrEn && wrData && !clkSelLow && mainClkSel;
  assign invByte  = ~statusByte;

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (extClkSel || !oscModeSel || mainStop) && !wrEn && !stopEnter && !stopRelease
      |=> $stable(statusByte));

  // Zeros only below ones: the inverse is a low-aligned mask
  assert_thermo_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((invByte & (invByte + NUM_BITS'(1))) == '0));

  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopEnter |=> statusByte == '0);

  assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopRelease |=> statusByte == '0);

  assert_stop_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData && !badWrite |=> mainStop && statusByte == '0);

  assert_reject_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    badWrite |=> wrReject && mainStop == $past(mainStop));

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !badWrite |=> !wrReject);

  assert_bit_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    statusBit == statusByte[bitSel]);

endmodule

bind oscSettleStatus oscSettleChk #(.NUM_BITS(NUM_BITS), .SEL_W(SEL_W)) uChk (
  .clk(clk), .rstN(rstN), .stopEnter(stopEnter), .stopRelease(stopRelease),
  .extClkSel(extClkSel), .oscModeSel(oscModeSel), .clkSelLow(clkSelLow),
  .mainClkSel(mainClkSel), .wrEn(wrEn), .wrData(wrData), .bitSel(bitSel),
  .statusByte(statusByte), .statusBit(statusBit), .mainStop(mainStop),
  .wrReject(wrReject)
);

// File: tb/sim_oscSettleStatus.sv
`timescale 1ns/1ps
module sim_oscSettleStatus;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stopEnter = 1'b0, stopRelease = 1'b0;
  logic       extClkSel = 1'b0, oscModeSel = 1'b1;
  logic       clkSelLow = 1'b1, mainClkSel = 1'b0;
  logic       wrEn = 1'b0, wrData = 1'b0;
  logic [2:0] bitSel = 3'd0;
  logic [7:0] statusByte;
  logic       statusBit, mainStop, wrReject;

  always #10 clk = ~clk;  // 50 MHz

  oscSettleStatus u0 (
    .clk(clk), .rstN(rstN), .stopEnter(stopEnter), .stopRelease(stopRelease),
    .extClkSel(extClkSel), .oscModeSel(oscModeSel), .clkSelLow(clkSelLow),
    .mainClkSel(mainClkSel), .wrEn(wrEn), .wrData(wrData), .bitSel(bitSel),
    .statusByte(statusByte), .statusBit(statusBit), .mainStop(mainStop),
    .wrReject(wrReject)
  );

  integer nTotal = 0, nFail = 0;
  integer mCount = 0;
  bit     mStop = 1'b1, mRej = 1'b0, live = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTotal++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] expByte(input integer c);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = (c >= (1 << (8 + i)));
    return b;
  endfunction

  // Behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    bit permit, setOk, clr, run;
    if (!rstN) begin
      mCount = 0; mStop = 1'b1; mRej = 1'b0;
    end else begin
      permit = clkSelLow || !mainClkSel;
      setOk  = wrEn && wrData && permit;
      clr    = stopEnter || stopRelease || setOk;
      run    = !extClkSel && oscModeSel && !mStop;
      mRej   = wrEn && wrData && !permit;
      if (clr) mCount = 0;
      else if (run && mCount < 32768) mCount = mCount + 1;
      if (setOk) mStop = 1'b1;
      else if (wrEn && !wrData) mStop = 1'b0;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      check("R3", statusByte, expByte(mCount));
      check("R6", mainStop, mStop);
      check("R8", wrReject, mRej);
      check("R10", statusBit, expByte(mCount)[bitSel]);
    end
  end

  task automatic tick(input integer n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeStop(input logic v);
    wrEn = 1'b1; wrData = v; tick(1); wrEn = 1'b0; wrData = 1'b0;
  endtask

  task automatic waitCount(input integer c);
    while (mCount != c) @(negedge clk);
  endtask

  initial begin
    tick(3);
    check("R1", statusByte, 8'h00);
    check("R1", mainStop, 1'b1);
    check("R1", wrReject, 1'b0);
    rstN = 1'b1; live = 1'b1;
    tick(1);
    check("R1", statusByte, 8'h00);

    // Oscillator stopped: no progress
    tick(300);
    check("R2", statusByte, 8'h00);

    // Start and cross the first thresholds exactly
    writeStop(1'b0);
    check("R6", mainStop, 1'b0);
    waitCount(255);
    check("R3", statusByte, 8'h00);
    tick(1);
    check("R3", statusByte, 8'h80);
    waitCount(511);
    check("R3", statusByte, 8'h80);
    tick(1);
    check("R3", statusByte, 8'hC0);

    // Bit reads at count between 512 and 1023
    for (int k = 0; k < 8; k++) begin
      bitSel = 3'(k); #1;
      check("R10", statusBit, (k >= 6) ? 1'b1 : 1'b0);
    end
    bitSel = 3'd0;

    // Stop entry mid-count
    waitCount(3000);
    stopEnter = 1'b1; tick(1); stopEnter = 1'b0;
    check("R4", statusByte, 8'h00);

    // Stop release while running: clear wins, then 256 edges to bit 7
    waitCount(700);
    stopRelease = 1'b1; tick(1); stopRelease = 1'b0;
    check("R5", statusByte, 8'h00);
    tick(255);
    check("R9", statusByte, 8'h00);
    tick(1);
    check("R9", statusByte, 8'h80);

    // Rejected write of 1
    waitCount(600);
    clkSelLow = 1'b0; mainClkSel = 1'b1;
    writeStop(1'b1);
    check("R8", wrReject, 1'b1);
    check("R7", mainStop, 1'b0);
    check("R7", statusByte, 8'hC0);
    tick(1);
    check("R8", wrReject, 1'b0);

    // Permitted write of 1 with clkSelLow=0, mainClkSel=0
    mainClkSel = 1'b0;
    writeStop(1'b1);
    check("R6", mainStop, 1'b1);
    check("R6", statusByte, 8'h00);
    check("R7", wrReject, 1'b0);
    tick(300);
    check("R2", statusByte, 8'h00);

    // External clock or oscillator disabled: no counting
    extClkSel = 1'b1;
    writeStop(1'b0);
    tick(300);
    check("R2", statusByte, 8'h00);
    extClkSel = 1'b0; oscModeSel = 1'b0;
    tick(300);
    check("R2", statusByte, 8'h00);

    // Permitted write with clkSelLow=1 while high-speed select is set
    clkSelLow = 1'b1; mainClkSel = 1'b1;
    writeStop(1'b1);
    check("R7", mainStop, 1'b1);
    check("R8", wrReject, 1'b0);

    // Full run to saturation
    oscModeSel = 1'b1;
    writeStop(1'b0);
    waitCount(32767);
    check("R3", statusByte, 8'hFE);
    tick(1);
    check("R3", statusByte, 8'hFF);
    tick(500);
    check("R3", statusByte, 8'hFF);

    live = 1'b0;
    $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nTotal++; nFail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nTotal - nFail, nTotal);
    $finish;
  end

endmodule